// File: doc/BRIEF.md
# Run, Restart and Interrupt Entry Controller

This controller sits in front of the instruction-interpretation loop of a small CPU. It keeps the run flag and turns start and restart requests into clear strobes for the program counter, the control step counter and the register file. When the control sequencer reports an instruction boundary, it either starts the next fetch or enters an external interrupt. Entering an interrupt saves the current PC and the source information, pulses the acknowledge, disables interrupts and jumps to the vector.

The decision is taken from the inputs seen at one rising edge. Every strobe and data output is registered and is valid for exactly the cycle after that edge. The interrupt request is looked at only in a boundary cycle, so the instruction in progress always completes first. All pins are plain control and status signals. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. The sequencer acts on each strobe in the cycle it is high.

Top module: `intr_entry_ctl`

## Requirements
- R1: After `rst_n` is low, `run` and `ie` read 0 and every strobe (`pc_wr`, `step_clr`, `regs_clr`, `ipc_wr`, `info_wr`, `iack`, `fetch_go`) reads 0.
- R2: While `run` is 0, `start_req` at an edge sets `run` to 1. In the following cycle `pc_wr` is 1 with `pc_wdata` 0, and `regs_clr` and `step_clr` are 1, each for one cycle. While `run` is 1, `start_req` has no effect.
- R3: While running, `reset_req` at an edge gives `pc_wr` with `pc_wdata` 0 and `step_clr` in the next cycle, with no `regs_clr`, and no boundary is needed. While `run` is 0, `reset_req` produces no strobe.
- R4: While running, a boundary with no reset and no enabled pending interrupt (`irq_req` AND `ie` false) gives a one-cycle `fetch_go` in the next cycle, and `pc_wr` stays 0.
- R5: While running, a boundary with `irq_req` and `ie` both 1 and no reset gives, in the next cycle: `ipc_wr` with `ipc_wdata` equal to `pc_in` from the deciding edge; `info_wr` with `info_wdata` equal to `src_info` from that edge; `iack`; and `pc_wr` with `pc_wdata` equal to `vec_in`.
- R6: `ie` becomes 0 in the cycle of `iack` and stays 0 until `ie_set` is seen. `ie_set` makes `ie` 1 in the next cycle. If `ie_set` and an acceptance fall on the same edge, the acceptance wins and `ie` reads 0.
- R7: `irq_req` outside a boundary cycle has no effect. At a boundary with `ie` 0 it is not accepted, and a fetch starts instead.
- R8: When `reset_req` and an acceptable interrupt meet at the same boundary, the restart is taken: `step_clr` is 1, and `iack`, `ipc_wr` and `fetch_go` are 0.
- R9: `iack` is high for exactly one cycle. At most one of `iack`, `fetch_go` and `step_clr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| start_req | input | 1 | Start request |
| reset_req | input | 1 | Restart request while running |
| boundary | input | 1 | Sequencer is at an instruction boundary |
| irq_req | input | 1 | External interrupt request |
| ie_set | input | 1 | Enable interrupts |
| pc_in | input | AW | Current PC |
| vec_in | input | AW | Interrupt vector address |
| src_info | input | IW | Interrupt source information |
| run | output | 1 | Run flag |
| ie | output | 1 | Interrupt enable flag |
| pc_wr | output | 1 | Write `pc_wdata` into the PC |
| pc_wdata | output | AW | New PC value (0 or the vector) |
| step_clr | output | 1 | Clear the control step counter |
| regs_clr | output | 1 | Clear the register file |
| ipc_wr | output | 1 | Load the saved-PC register |
| ipc_wdata | output | AW | Value for the saved-PC register |
| info_wr | output | 1 | Load the interrupt information register |
| info_wdata | output | IW | Value for the information register |
| iack | output | 1 | Interrupt acknowledge pulse |
| fetch_go | output | 1 | Begin the next instruction fetch |

## Verification
Three pairs of events can land on the same edge: a restart and an interrupt acceptance at one boundary, an `ie_set` and an acceptance, and a `start_req` while the block is already running. Directed steps force each of these collisions. A seeded random stream also produces them naturally by raising `reset_req`, `ie_set` and `irq_req` independently of `boundary`. Each cycle's outputs are compared with a bench model built from the priority order in R3 to R8, so in a collision the losing action must leave no strobe at all.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  // Action picked at one clock edge; ordered by how it is resolved.
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_START = 3'd1,
    ACT_RESET = 3'd2,
    ACT_IRQ   = 3'd3,
    ACT_FETCH = 3'd4
  } act_e;
endpackage

// File: rtl/intr_entry_arbiter.sv
module intr_entry_arbiter
  import intr_entry_pkg::*;
(
  input  logic run,
  input  logic start_req,
  input  logic reset_req,
  input  logic boundary,
  input  logic irq_req,
  input  logic ie,
  output act_e act
);
  // Priority: start (idle only) > restart > interrupt at boundary > fetch.
  always_comb begin
    act = ACT_NONE;
    if (!run) begin
      if (start_req) act = ACT_START;
    end else if (reset_req) begin
      act = ACT_RESET;
    end else if (boundary) begin
      act = (irq_req && ie) ? ACT_IRQ : ACT_FETCH;
    end
  end
endmodule

// File: rtl/intr_entry_ie.sv
module intr_entry_ie (
  input  logic clk,
  input  logic rst_n,
  input  logic ie_set,
  input  logic take,
  output logic ie
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ie <= 1'b0;
    else if (take)   ie <= 1'b0;
    else if (ie_set) ie <= 1'b1;
  end

  p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie);
  p_set_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set && !take) |=> ie);
  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !ie_set) |=> !ie);
endmodule

// File: rtl/intr_entry_issue.sv
module intr_entry_issue
  import intr_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  act_e          act,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] vec_in,
  input  logic [IW-1:0] src_info,
  output logic          run,
  output logic          pc_wr,
  output logic [AW-1:0] pc_wdata,
  output logic          step_clr,
  output logic          regs_clr,
  output logic          ipc_wr,
  output logic [AW-1:0] ipc_wdata,
  output logic          info_wr,
  output logic [IW-1:0] info_wdata,
  output logic          iack,
  output logic          fetch_go
);
  localparam logic [AW-1:0] PC_ZERO = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      pc_wr      <= 1'b0;
      pc_wdata   <= PC_ZERO;
      step_clr   <= 1'b0;
      regs_clr   <= 1'b0;
      ipc_wr     <= 1'b0;
      ipc_wdata  <= PC_ZERO;
      info_wr    <= 1'b0;
      info_wdata <= '0;
      iack       <= 1'b0;
      fetch_go   <= 1'b0;
    end else begin
      pc_wr    <= (act == ACT_START) || (act == ACT_RESET) || (act == ACT_IRQ);
      pc_wdata <= (act == ACT_IRQ) ? vec_in : PC_ZERO;
      step_clr <= (act == ACT_START) || (act == ACT_RESET);
      regs_clr <= (act == ACT_START);
      ipc_wr   <= (act == ACT_IRQ);
      info_wr  <= (act == ACT_IRQ);
      iack     <= (act == ACT_IRQ);
      fetch_go <= (act == ACT_FETCH);
      if (act == ACT_START) run <= 1'b1;
      if (act == ACT_IRQ) begin
        ipc_wdata  <= pc_in;
        info_wdata <= src_info;
      end
    end
  end

  p_iack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> !iack);
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iack, fetch_go, step_clr}));
  p_iack_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> (ipc_wr && info_wr && pc_wr));
  p_regs_clr_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clr |-> (step_clr && pc_wr && pc_wdata == PC_ZERO));
  p_run_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);
endmodule

// File: rtl/intr_entry_ctl.sv
module intr_entry_ctl
  import intr_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          reset_req,
  input  logic          boundary,
  input  logic          irq_req,
  input  logic          ie_set,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] vec_in,
  input  logic [IW-1:0] src_info,
  output logic          run,
  output logic          ie,
  output logic          pc_wr,
  output logic [AW-1:0] pc_wdata,
  output logic          step_clr,
  output logic          regs_clr,
  output logic          ipc_wr,
  output logic [AW-1:0] ipc_wdata,
  output logic          info_wr,
  output logic [IW-1:0] info_wdata,
  output logic          iack,
  output logic          fetch_go
);
  act_e act;

  intr_entry_arbiter u_arb (
    .run(run), .start_req(start_req), .reset_req(reset_req),
    .boundary(boundary), .irq_req(irq_req), .ie(ie), .act(act)
  );

  intr_entry_ie u_ie (
    .clk(clk), .rst_n(rst_n), .ie_set(ie_set),
    .take(act == ACT_IRQ), .ie(ie)
  );

  intr_entry_issue #(.AW(AW), .IW(IW)) u_issue (
    .clk(clk), .rst_n(rst_n), .act(act), .pc_in(pc_in), .vec_in(vec_in),
    .src_info(src_info), .run(run), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
    .step_clr(step_clr), .regs_clr(regs_clr), .ipc_wr(ipc_wr),
    .ipc_wdata(ipc_wdata), .info_wr(info_wr), .info_wdata(info_wdata),
    .iack(iack), .fetch_go(fetch_go)
  );

  p_reset_beats_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reset_req && boundary && irq_req && ie) |=> (step_clr && !iack));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_req) |=> (!pc_wr && !step_clr && !fetch_go));
  p_no_boundary_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !iack);
  p_ack_clears_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> !ie);
endmodule

// File: tb/intr_entry_ctl_bench.sv
module intr_entry_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 0, reset_req = 0, boundary = 0, irq_req = 0, ie_set = 0;
  logic [AW-1:0] pc_in = '0, vec_in = '0;
  logic [IW-1:0] src_info = '0;
  logic run, ie, pc_wr, step_clr, regs_clr, ipc_wr, info_wr, iack, fetch_go;
  logic [AW-1:0] pc_wdata, ipc_wdata;
  logic [IW-1:0] info_wdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit run_m = 0;
  bit ie_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_ctl #(.AW(AW), .IW(IW)) u_intr_entry_ctl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reset_req(reset_req),
    .boundary(boundary), .irq_req(irq_req), .ie_set(ie_set), .pc_in(pc_in),
    .vec_in(vec_in), .src_info(src_info), .run(run), .ie(ie), .pc_wr(pc_wr),
    .pc_wdata(pc_wdata), .step_clr(step_clr), .regs_clr(regs_clr),
    .ipc_wr(ipc_wr), .ipc_wdata(ipc_wdata), .info_wr(info_wr),
    .info_wdata(info_wdata), .iack(iack), .fetch_go(fetch_go)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // Expected action code: 0 none, 1 start, 2 restart, 3 interrupt, 4 fetch
  function automatic int exp_act(bit r_m, bit i_m, bit s, bit r, bit b, bit q);
    if (!r_m) return s ? 1 : 0;
    if (r) return 2;
    if (b) return (q && i_m) ? 3 : 4;
    return 0;
  endfunction

  function automatic string pick_tag(bit r_m, bit i_m, bit s, bit r, bit b, bit q, bit e);
    if (!r_m) return s ? "R2" : (r ? "R3" : "R1");
    if (r && b && q && i_m) return "R8";
    if (r) return "R3";
    if (b && q && i_m) return e ? "R6" : "R5";
    if (q) return "R7";
    if (b) return "R4";
    if (s) return "R2";
    if (e) return "R6";
    return "R9";
  endfunction

  task automatic step(input bit s, input bit r, input bit b, input bit q, input bit e,
                      input logic [AW-1:0] pc, input logic [AW-1:0] vec,
                      input logic [IW-1:0] inf, input string tag_in);
    int a;
    string tag;
    bit exp_ie;
    tag = (tag_in == "") ? pick_tag(run_m, ie_m, s, r, b, q, e) : tag_in;
    start_req = s; reset_req = r; boundary = b; irq_req = q; ie_set = e;
    pc_in = pc; vec_in = vec; src_info = inf;
    a = exp_act(run_m, ie_m, s, r, b, q);
    exp_ie = (a == 3) ? 1'b0 : (e ? 1'b1 : ie_m);
    if (a == 1) run_m = 1;
    ie_m = exp_ie;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "run", 64'(run), 64'(run_m));
    chk(tag, "ie", 64'(ie), 64'(exp_ie));
    chk(tag, "pc_wr", 64'(pc_wr), 64'(a == 1 || a == 2 || a == 3));
    if (a == 1 || a == 2 || a == 3)
      chk(tag, "pc_wdata", 64'(pc_wdata), (a == 3) ? 64'(vec) : 64'd0);
    chk(tag, "step_clr", 64'(step_clr), 64'(a == 1 || a == 2));
    chk(tag, "regs_clr", 64'(regs_clr), 64'(a == 1));
    chk(tag, "iack", 64'(iack), 64'(a == 3));
    chk(tag, "ipc_wr", 64'(ipc_wr), 64'(a == 3));
    chk(tag, "info_wr", 64'(info_wr), 64'(a == 3));
    chk(tag, "fetch_go", 64'(fetch_go), 64'(a == 4));
    if (a == 3) begin
      chk(tag, "ipc_wdata", 64'(ipc_wdata), 64'(pc));
      chk(tag, "info_wdata", 64'(info_wdata), 64'(inf));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: state after hardware reset
    chk("R1", "run", 64'(run), 0);
    chk("R1", "ie", 64'(ie), 0);
    chk("R1", "strobes", 64'({pc_wr, step_clr, regs_clr, ipc_wr, info_wr, iack, fetch_go}), 0);
    // R3: restart while idle is ignored; R7: interrupt while idle too
    step(0, 1, 1, 1, 0, 32'h40, 32'h800, 8'h11, "R3");
    // R2: start, then start again while running is ignored
    step(1, 0, 0, 0, 0, 32'h44, 32'h800, 8'h00, "R2");
    step(1, 0, 0, 0, 0, 32'h48, 32'h800, 8'h00, "R2");
    // R7: boundary with ie off, interrupt not taken
    step(0, 0, 1, 1, 0, 32'h4c, 32'h800, 8'h22, "R7");
    // R6: enable, then acceptance with ie_set on the same edge
    step(0, 0, 0, 0, 1, 32'h50, 32'h800, 8'h00, "R6");
    step(0, 0, 1, 1, 1, 32'h1234, 32'h900, 8'h5a, "R6");
    // R9: request held, next boundary fetches because ie is off
    step(0, 0, 1, 1, 0, 32'h900, 32'h900, 8'h5a, "R9");
    // R7: request away from a boundary
    step(0, 0, 0, 0, 1, 32'h904, 32'h900, 8'h00, "R6");
    step(0, 0, 0, 1, 0, 32'h904, 32'h900, 8'h33, "R7");
    // R5: plain acceptance
    step(0, 0, 1, 1, 0, 32'hcafe, 32'ha00, 8'h77, "R5");
    // R8: restart meets acceptable interrupt
    step(0, 0, 0, 0, 1, 32'ha00, 32'ha00, 8'h00, "R6");
    step(0, 1, 1, 1, 0, 32'ha04, 32'hb00, 8'h44, "R8");
    // R3: restart with no boundary; R4: plain fetch
    step(0, 1, 0, 0, 0, 32'h0, 32'hb00, 8'h00, "R3");
    step(0, 0, 1, 0, 0, 32'h0, 32'hb00, 8'h00, "R4");
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 5, ($urandom % 100) < 6, ($urandom % 100) < 35,
           ($urandom % 100) < 50, ($urandom % 100) < 12,
           $urandom, $urandom, IW'($urandom), "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule